// File: doc/BRIEF.md
# Calendar Update Engine

This block keeps a real-time calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Once per second a tick starts an update. An update-in-progress flag is raised for a fixed number of clock cycles. The new time then appears in the same cycle that the flag drops. Month lengths follow the Gregorian leap rule, and the century is a build parameter.

The time is shown either in BCD or in binary, and hours in either 24-hour or 12-hour form. The mode inputs pick the form, and a mode change shows up at once on the outputs. A load strobe writes all seven time bytes, read in the current form.

When a second has been committed, the new seconds, minutes and hours are compared against three alarm bytes. An alarm byte that has both top bits set matches any value. The result, together with the update-ended event, is reported as a one-cycle status mask. A status register elsewhere in the chip ORs that mask into its own bits.

Top module: `calendar_update_engine`

## Requirements
- R1: A tick starts an update only when `divField` equals 3'b010. With any other code the tick is ignored: `uip` stays 0 and the time does not change.
- R2: While `modeSet` is 1, ticks are ignored. If `modeSet` rises while an update is pending, `uip` falls on the next cycle, the time keeps its old value and no flags are produced.
- R3: `uip` rises in the cycle after the clock edge that samples the tick. It stays high for exactly `UIP_CYCLES` cycles, and the time outputs do not change while it is high. `uip` falls in the same cycle that the advanced time first appears.
- R4: With `modeBin`=1 each time byte is a plain binary value. With `modeBin`=0 it is BCD, with tens in bits 7:4 and units in bits 3:0. Changing the mode re-encodes the held time at once.
- R5: With `modeH24`=0 the hour byte holds hour mod 12, with 0 shown as 12, and bit 7 set for PM (hours 12 to 23). With `modeH24`=1 it holds 0 to 23, and bit 7 is 0.
- R6: Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day. Day of week counts 1 to 7 and wraps from 7 to 1 on each new day.
- R7: Day of month wraps to 1 after the last day of the month; February has 29 days in a leap year. A year is a leap year when the full year (CENTURY*100 + year) is divisible by 4, and either not by 100 or by 400. Month wraps from 12 to 1 and increments the year, which wraps from 99 to 0.
- R8: After a commit, if `alarmEn` is 1 and each of the three alarm bytes either equals the live seconds, minutes or hours byte in the current encoding or has bits 7:6 = 2'b11, then `flagSet` bits 7 and 5 are set.
- R9: After a commit with `updEn`=1, `flagSet` bits 7 and 4 are set, so both events together give 8'hB0. `flagSet` is nonzero only for the single cycle in which the new time first appears.
- R10: `loadEn` writes the seven load bytes, decoded in the current encoding, on the next clock edge. A load during a pending update cancels that update: `uip` drops, the loaded time stays, and no flags are produced.
- R11: A tick that arrives while an update is pending, or in its flag cycle, is ignored. Each accepted tick advances the time by exactly one second.
- R12: After reset the time is 00:00:00, day of week 1, date 1, month 1, year 0, and both `uip` and `flagSet` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| secTick | input | 1 | One-cycle pulse once per second |
| divField | input | 3 | Oscillator/divider code; 3'b010 means running |
| modeSet | input | 1 | Freezes the time against updates |
| modeBin | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| modeH24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarmEn | input | 1 | Enables the alarm flag |
| updEn | input | 1 | Enables the update-ended flag |
| alarmSec | input | 8 | Seconds alarm byte |
| alarmMin | input | 8 | Minutes alarm byte |
| alarmHour | input | 8 | Hours alarm byte |
| loadEn | input | 1 | Writes the load bytes into the time |
| loadSec | input | 8 | Seconds to load |
| loadMin | input | 8 | Minutes to load |
| loadHour | input | 8 | Hours to load |
| loadDow | input | 8 | Day of week to load |
| loadDom | input | 8 | Day of month to load |
| loadMon | input | 8 | Month to load |
| loadYear | input | 8 | Year to load |
| timeSec | output | 8 | Seconds |
| timeMin | output | 8 | Minutes |
| timeHour | output | 8 | Hours |
| timeDow | output | 8 | Day of week |
| timeDom | output | 8 | Day of month |
| timeMon | output | 8 | Month |
| timeYear | output | 8 | Year |
| uip | output | 1 | Update in progress |
| flagSet | output | 8 | One-cycle mask of status bits to set |

## Verification
Two pairs of events can fall in the same cycle. The first is the alarm match and the update-ended event, which both come from the same commit. The bench enables both flags and sets the alarm bytes to the expected next time or to don't-care codes, and it expects 8'hB0 for exactly one cycle. The second is a load, or a rising freeze, that lands on a pending update. The bench drives it in the middle of the in-progress window and expects the loaded or frozen time to survive, with `uip` low and no flag pulse afterwards.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic advance;
    logic evalFlags;
  } ctlStrobe_t;

  localparam logic [2:0] DIV_NORMAL = 3'b010;

  // value 0..99 to register byte
  function automatic logic [7:0] encVal(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  // register byte to value
  function automatic logic [6:0] decVal(input logic [7:0] b, input logic bin);
    logic [6:0] hi;
    logic [6:0] lo;
    hi = {3'b000, b[7:4]};
    lo = {3'b000, b[3:0]};
    return bin ? b[6:0] : (hi * 7'd10 + lo);
  endfunction

  // hour 0..23 to register byte
  function automatic logic [7:0] encHour(input logic [6:0] h, input logic bin, input logic h24);
    logic       pm;
    logic [6:0] h12;
    logic [7:0] e;
    pm  = (h >= 7'd12);
    h12 = pm ? (h - 7'd12) : h;
    if (h12 == 7'd0) h12 = 7'd12;
    e = encVal(h12, bin);
    return h24 ? encVal(h, bin) : {pm, e[6:0]};
  endfunction

  // register byte to hour 0..23
  function automatic logic [6:0] decHour(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] v;
    logic [6:0] base;
    v    = decVal({1'b0, b[6:0]}, bin);
    base = (v == 7'd12) ? 7'd0 : v;
    return h24 ? decVal(b, bin) : (b[7] ? base + 7'd12 : base);
  endfunction

  function automatic logic [6:0] daysInMonth(input logic [6:0] mon, input logic leap);
    case (mon)
      7'd2:                      return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl import cal_pkg::*; #(
  parameter int UIP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secTick,
  input  logic [2:0] divField,
  input  logic       setMode,
  input  logic       loadEn,
  output ctlStrobe_t strobe,
  output logic       uip
);

  localparam int CNT_W = $clog2(UIP_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UIP_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_FLAG} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             startOk;
  logic             done;

  always_comb begin
    startOk          = secTick && (divField == DIV_NORMAL) && !setMode && !loadEn;
    done             = (state == S_WAIT) && (cnt == LAST);
    strobe.advance   = done && !setMode && !loadEn;
    strobe.evalFlags = (state == S_FLAG);
    uip              = (state == S_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (startOk) state <= S_WAIT;
        end
        S_WAIT: begin
          if (loadEn || setMode) begin
            state <= S_IDLE;
          end else if (done) begin
            state <= S_FLAG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FLAG:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: a tick with a stopped divider never opens a window
  assert_bad_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && secTick && divField != DIV_NORMAL) |=> !uip);

  // R2: freezing the time closes a pending window
  assert_set_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (setMode && uip) |=> !uip);

  // R3: every window starts with a cleared counter
  assert_uip_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> (cnt == '0));

  // R11: ticks while busy do not restart a window
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && secTick) |=> !$rose(uip));

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] alarm,
  output logic         match
);
  logic anyValue;
  assign anyValue = &alarm[W-1:W-2];
  assign match    = anyValue || (alarm == live);
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath import cal_pkg::*; #(
  parameter int CENTURY = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctlStrobe_t strobe,
  input  logic       modeBin,
  input  logic       modeH24,
  input  logic       alarmEn,
  input  logic       updEn,
  input  logic [7:0] alarmSec,
  input  logic [7:0] alarmMin,
  input  logic [7:0] alarmHour,
  input  logic       loadEn,
  input  logic [7:0] loadSec,
  input  logic [7:0] loadMin,
  input  logic [7:0] loadHour,
  input  logic [7:0] loadDow,
  input  logic [7:0] loadDom,
  input  logic [7:0] loadMon,
  input  logic [7:0] loadYear,
  output logic [7:0] timeSec,
  output logic [7:0] timeMin,
  output logic [7:0] timeHour,
  output logic [7:0] timeDow,
  output logic [7:0] timeDom,
  output logic [7:0] timeMon,
  output logic [7:0] timeYear,
  output logic [7:0] flagSet
);

  localparam bit CENT_LEAP = ((CENTURY % 4) == 0);
  localparam int NFIELD    = 3;

  logic [6:0] secCnt, minCnt, hourCnt, dowCnt, domCnt, monCnt, yearCnt;
  logic [6:0] secN, minN, hourN, dowN, domN, monN, yearN;
  logic       cMin, cHour, cDay, cMon, cYear;
  logic       leap;
  logic [6:0] dim;

  // next-second arithmetic, all in binary
  always_comb begin
    leap  = (yearCnt[1:0] == 2'b00) && ((yearCnt != 7'd0) || CENT_LEAP);
    dim   = daysInMonth(monCnt, leap);
    cMin  = (secCnt >= 7'd59);
    secN  = cMin ? 7'd0 : secCnt + 7'd1;
    cHour = cMin && (minCnt >= 7'd59);
    minN  = cMin ? ((minCnt >= 7'd59) ? 7'd0 : minCnt + 7'd1) : minCnt;
    cDay  = cHour && (hourCnt >= 7'd23);
    hourN = cHour ? ((hourCnt >= 7'd23) ? 7'd0 : hourCnt + 7'd1) : hourCnt;
    dowN  = cDay ? ((dowCnt >= 7'd7) ? 7'd1 : dowCnt + 7'd1) : dowCnt;
    cMon  = cDay && (domCnt >= dim);
    domN  = cDay ? ((domCnt >= dim) ? 7'd1 : domCnt + 7'd1) : domCnt;
    cYear = cMon && (monCnt >= 7'd12);
    monN  = cMon ? ((monCnt >= 7'd12) ? 7'd1 : monCnt + 7'd1) : monCnt;
    yearN = cYear ? ((yearCnt >= 7'd99) ? 7'd0 : yearCnt + 7'd1) : yearCnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secCnt  <= 7'd0;
      minCnt  <= 7'd0;
      hourCnt <= 7'd0;
      dowCnt  <= 7'd1;
      domCnt  <= 7'd1;
      monCnt  <= 7'd1;
      yearCnt <= 7'd0;
    end else if (loadEn) begin
      secCnt  <= decVal(loadSec, modeBin);
      minCnt  <= decVal(loadMin, modeBin);
      hourCnt <= decHour(loadHour, modeBin, modeH24);
      dowCnt  <= decVal(loadDow, modeBin);
      domCnt  <= decVal(loadDom, modeBin);
      monCnt  <= decVal(loadMon, modeBin);
      yearCnt <= decVal(loadYear, modeBin);
    end else if (strobe.advance) begin
      secCnt  <= secN;
      minCnt  <= minN;
      hourCnt <= hourN;
      dowCnt  <= dowN;
      domCnt  <= domN;
      monCnt  <= monN;
      yearCnt <= yearN;
    end
  end

  // presentation in the selected encoding
  always_comb begin
    timeSec  = encVal(secCnt, modeBin);
    timeMin  = encVal(minCnt, modeBin);
    timeHour = encHour(hourCnt, modeBin, modeH24);
    timeDow  = encVal(dowCnt, modeBin);
    timeDom  = encVal(domCnt, modeBin);
    timeMon  = encVal(monCnt, modeBin);
    timeYear = encVal(yearCnt, modeBin);
  end

  // alarm comparison against the live bytes
  logic [7:0]        liveVec [NFIELD];
  logic [7:0]        almVec  [NFIELD];
  logic [NFIELD-1:0] matchVec;

  always_comb begin
    liveVec[0] = timeSec;
    liveVec[1] = timeMin;
    liveVec[2] = timeHour;
    almVec[0]  = alarmSec;
    almVec[1]  = alarmMin;
    almVec[2]  = alarmHour;
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_alarm
    cal_alarm_match #(.W(8)) u_match (
      .live  (liveVec[i]),
      .alarm (almVec[i]),
      .match (matchVec[i])
    );
  end

  logic alarmHit;
  always_comb begin
    alarmHit = alarmEn && (&matchVec);
    flagSet  = strobe.evalFlags
             ? {alarmHit || updEn, 1'b0, alarmHit, updEn, 4'b0000}
             : 8'h00;
  end

  // R9: the flag mask lasts one cycle only
  assert_flag_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flagSet != 8'h00) |=> (flagSet == 8'h00));

  // R8: only bits 7, 5 and 4 may ever be set, and bit 7 goes with any of them
  assert_flag_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flagSet != 8'h00) |-> (flagSet[7] && !flagSet[6] && flagSet[3:0] == 4'h0));

  // R3: without a commit or load the held time is frozen
  assert_time_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.advance && !loadEn) |=>
      $stable({secCnt, minCnt, hourCnt, dowCnt, domCnt, monCnt, yearCnt}));

  // R6: seconds wrap to zero
  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !loadEn && secCnt >= 7'd59) |=> (secCnt == 7'd0));

endmodule

// File: rtl/calendar_update_engine.sv
module calendar_update_engine import cal_pkg::*; #(
  parameter int UIP_CYCLES = 8,
  parameter int CENTURY    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secTick,
  input  logic [2:0] divField,
  input  logic       modeSet,
  input  logic       modeBin,
  input  logic       modeH24,
  input  logic       alarmEn,
  input  logic       updEn,
  input  logic [7:0] alarmSec,
  input  logic [7:0] alarmMin,
  input  logic [7:0] alarmHour,
  input  logic       loadEn,
  input  logic [7:0] loadSec,
  input  logic [7:0] loadMin,
  input  logic [7:0] loadHour,
  input  logic [7:0] loadDow,
  input  logic [7:0] loadDom,
  input  logic [7:0] loadMon,
  input  logic [7:0] loadYear,
  output logic [7:0] timeSec,
  output logic [7:0] timeMin,
  output logic [7:0] timeHour,
  output logic [7:0] timeDow,
  output logic [7:0] timeDom,
  output logic [7:0] timeMon,
  output logic [7:0] timeYear,
  output logic       uip,
  output logic [7:0] flagSet
);

  ctlStrobe_t strobe;

  cal_ctrl #(.UIP_CYCLES(UIP_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .secTick  (secTick),
    .divField (divField),
    .setMode  (modeSet),
    .loadEn   (loadEn),
    .strobe   (strobe),
    .uip      (uip)
  );

  cal_datapath #(.CENTURY(CENTURY)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .modeBin   (modeBin),
    .modeH24   (modeH24),
    .alarmEn   (alarmEn),
    .updEn     (updEn),
    .alarmSec  (alarmSec),
    .alarmMin  (alarmMin),
    .alarmHour (alarmHour),
    .loadEn    (loadEn),
    .loadSec   (loadSec),
    .loadMin   (loadMin),
    .loadHour  (loadHour),
    .loadDow   (loadDow),
    .loadDom   (loadDom),
    .loadMon   (loadMon),
    .loadYear  (loadYear),
    .timeSec   (timeSec),
    .timeMin   (timeMin),
    .timeHour  (timeHour),
    .timeDow   (timeDow),
    .timeDom   (timeDom),
    .timeMon   (timeMon),
    .timeYear  (timeYear),
    .flagSet   (flagSet)
  );

endmodule

// File: tb/calendar_update_engine_test.sv
`timescale 1ns/1ps
module calendar_update_engine_test;

  localparam int UIP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic secTick = 1'b0;
  logic [2:0] divField = 3'b010;
  logic mSet = 1'b0, mBin = 1'b0, mH24 = 1'b1, mAie = 1'b0, mUie = 1'b0;
  logic [7:0] alSec = 8'h00, alMin = 8'h00, alHour = 8'h00;
  logic loadEn = 1'b0;
  logic [7:0] ldSec = 0, ldMin = 0, ldHour = 0, ldDow = 0, ldDom = 0, ldMon = 0, ldYear = 0;
  logic [7:0] tSec, tMin, tHour, tDow, tDom, tMon, tYear, flagSet;
  logic uip;
  logic [7:0] cSec, cMin, cHour, cDow, cDom, cMon, cYear, cFlag;
  logic cUip;

  int errCnt = 0;
  int chkCnt = 0;
  int mSec = 0, mMin = 0, mHour = 0, mDow = 1, mDom = 1, mMon = 1, mYear = 0;

  always #5 clk = ~clk;

  calendar_update_engine #(.UIP_CYCLES(UIP), .CENTURY(20)) uut (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .divField(divField),
    .modeSet(mSet), .modeBin(mBin), .modeH24(mH24), .alarmEn(mAie), .updEn(mUie),
    .alarmSec(alSec), .alarmMin(alMin), .alarmHour(alHour),
    .loadEn(loadEn), .loadSec(ldSec), .loadMin(ldMin), .loadHour(ldHour),
    .loadDow(ldDow), .loadDom(ldDom), .loadMon(ldMon), .loadYear(ldYear),
    .timeSec(tSec), .timeMin(tMin), .timeHour(tHour), .timeDow(tDow),
    .timeDom(tDom), .timeMon(tMon), .timeYear(tYear), .uip(uip), .flagSet(flagSet));

  // second copy in the next century, used only for the century leap rule
  calendar_update_engine #(.UIP_CYCLES(UIP), .CENTURY(21)) uutC (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .divField(divField),
    .modeSet(mSet), .modeBin(mBin), .modeH24(mH24), .alarmEn(mAie), .updEn(mUie),
    .alarmSec(alSec), .alarmMin(alMin), .alarmHour(alHour),
    .loadEn(loadEn), .loadSec(ldSec), .loadMin(ldMin), .loadHour(ldHour),
    .loadDow(ldDow), .loadDom(ldDom), .loadMon(ldMon), .loadYear(ldYear),
    .timeSec(cSec), .timeMin(cMin), .timeHour(cHour), .timeDow(cDow),
    .timeDom(cDom), .timeMon(cMon), .timeYear(cYear), .uip(cUip), .flagSet(cFlag));

  function automatic int bEnc(input int v, input bit bin);
    return bin ? v : (((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int bHour(input int h, input bit bin, input bit h24);
    int h12;
    if (h24) return bEnc(h, bin);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return bEnc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int bDim(input int mo, input int y, input int cent);
    int full;
    bit lp;
    full = cent * 100 + y;
    lp = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    case (mo)
      2: return lp ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic bit amatch(input int al, input int live);
    return ((al >> 6) == 3) || (al == live);
  endfunction

  function automatic int expFlags();
    bit hit;
    int f;
    hit = mAie && amatch(alSec, bEnc(mSec, mBin)) && amatch(alMin, bEnc(mMin, mBin))
          && amatch(alHour, bHour(mHour, mBin, mH24));
    f = 0;
    if (hit) f = f | 8'hA0;
    if (mUie) f = f | 8'h90;
    return f;
  endfunction

  task automatic stepModel();
    mSec++;
    if (mSec >= 60) begin
      mSec = 0; mMin++;
      if (mMin >= 60) begin
        mMin = 0; mHour++;
        if (mHour >= 24) begin
          mHour = 0;
          mDow = (mDow >= 7) ? 1 : mDow + 1;
          mDom++;
          if (mDom > bDim(mMon, mYear, 20)) begin
            mDom = 1; mMon++;
            if (mMon > 12) begin mMon = 1; mYear = (mYear + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkTime(input string tag);
    chk({tag, " sec"},  tSec,  bEnc(mSec, mBin));
    chk({tag, " min"},  tMin,  bEnc(mMin, mBin));
    chk({tag, " hour"}, tHour, bHour(mHour, mBin, mH24));
    chk({tag, " dow"},  tDow,  bEnc(mDow, mBin));
    chk({tag, " dom"},  tDom,  bEnc(mDom, mBin));
    chk({tag, " mon"},  tMon,  bEnc(mMon, mBin));
    chk({tag, " year"}, tYear, bEnc(mYear, mBin));
  endtask

  task automatic loadTime(input int s, input int mi, input int h, input int dw,
                          input int dm, input int mo, input int y);
    @(negedge clk);
    ldSec = 8'(bEnc(s, mBin)); ldMin = 8'(bEnc(mi, mBin)); ldHour = 8'(bHour(h, mBin, mH24));
    ldDow = 8'(bEnc(dw, mBin)); ldDom = 8'(bEnc(dm, mBin)); ldMon = 8'(bEnc(mo, mBin));
    ldYear = 8'(bEnc(y, mBin));
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    mSec = s; mMin = mi; mHour = h; mDow = dw; mDom = dm; mMon = mo; mYear = y;
  endtask

  // one accepted second, optionally with an extra tick inside the window (R11)
  task automatic oneSecond(input string tag, input bit extraTick);
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    chk({tag, " R3 uip rise"}, uip, 1);
    checkTime({tag, " R3 hold"});
    if (extraTick) secTick = 1'b1;
    repeat (UIP - 1) begin
      @(negedge clk);
      secTick = 1'b0;
    end
    chk({tag, " R3 uip still high"}, uip, 1);
    chk({tag, " R3 no early flag"}, flagSet, 0);
    @(negedge clk);
    stepModel();
    chk({tag, " R3 uip fall"}, uip, 0);
    checkTime({tag, " advance"});
    chk({tag, " R8 R9 flags"}, flagSet, expFlags());
    @(negedge clk);
    chk({tag, " R9 flag pulse ends"}, flagSet, 0);
    chk({tag, " R11 no restart"}, uip, 0);
  endtask

  // tick that must be ignored: no uip, no change, no flags
  task automatic ignoredTick(input string tag);
    bit sawUip;
    bit sawFlag;
    sawUip = 0; sawFlag = 0;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    repeat (UIP + 2) begin
      if (uip) sawUip = 1;
      if (flagSet != 0) sawFlag = 1;
      @(negedge clk);
    end
    chk({tag, " uip"}, int'(sawUip), 0);
    chk({tag, " flags"}, int'(sawFlag), 0);
    checkTime({tag, " unchanged"});
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    bit sawFlag;
    void'($urandom(32'h1c3a5e77));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state (24-hour BCD view)
    checkTime("R12 reset");
    chk("R12 reset uip", uip, 0);
    chk("R12 reset flags", flagSet, 0);

    // R4 encoding switch on the held time
    loadTime(45, 37, 23, 5, 28, 11, 19);
    chk("R4 bcd hour", tHour, 8'h23);
    chk("R4 bcd sec", tSec, 8'h45);
    mBin = 1'b1;
    #1;
    chk("R4 bin hour", tHour, 23);
    chk("R4 bin sec", tSec, 45);
    chk("R4 bin year", tYear, 19);
    mBin = 1'b0;

    // R6 plain seconds, then full day rollover
    oneSecond("R6 plain", 0);
    loadTime(59, 59, 23, 7, 14, 6, 33);
    oneSecond("R6 day and dow wrap", 0);

    // R7 month and year ends, leap rules
    loadTime(59, 59, 23, 3, 31, 12, 99);
    oneSecond("R7 year wrap", 0);
    loadTime(59, 59, 23, 2, 28, 2, 24);
    oneSecond("R7 leap feb 28", 0);
    loadTime(59, 59, 23, 2, 28, 2, 23);
    oneSecond("R7 common feb 28", 0);
    loadTime(59, 59, 23, 2, 30, 4, 50);
    oneSecond("R7 april 30", 0);
    loadTime(59, 59, 23, 2, 28, 2, 0);
    oneSecond("R7 year 00 century 20", 0);
    chk("R7 century 21 year 00 dom", cDom, 8'h01);
    chk("R7 century 21 year 00 mon", cMon, 8'h03);

    // R5 12-hour views
    mH24 = 1'b0;
    loadTime(59, 59, 11, 1, 10, 5, 10);
    oneSecond("R5 noon", 0);
    chk("R5 noon byte", tHour, 8'h92);
    loadTime(59, 59, 23, 1, 10, 5, 10);
    oneSecond("R5 midnight", 0);
    chk("R5 midnight byte", tHour, 8'h12);
    mBin = 1'b1;
    loadTime(59, 59, 12, 1, 10, 5, 10);
    oneSecond("R5 binary pm", 0);
    chk("R5 binary 13h byte", tHour, 8'h81);
    mBin = 1'b0;
    mH24 = 1'b1;

    // R1 stopped divider
    divField = 3'b011;
    ignoredTick("R1 div 011");
    divField = 3'b000;
    ignoredTick("R1 div 000");
    divField = 3'b010;

    // R2 freeze and abort
    mSet = 1'b1;
    ignoredTick("R2 set high");
    mSet = 1'b0;
    mUie = 1'b1;
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    chk("R2 window open", uip, 1);
    mSet = 1'b1;
    sawFlag = 0;
    @(negedge clk);
    chk("R2 abort uip", uip, 0);
    repeat (UIP + 2) begin
      if (flagSet != 0) sawFlag = 1;
      @(negedge clk);
    end
    chk("R2 abort flags", int'(sawFlag), 0);
    checkTime("R2 abort time");
    mSet = 1'b0;

    // R10 load cancels a pending update; load in 12-hour form
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    repeat (2) @(negedge clk);
    loadTime(10, 20, 7, 4, 15, 8, 41);
    chk("R10 cancel uip", uip, 0);
    sawFlag = 0;
    repeat (UIP + 2) begin
      if (flagSet != 0) sawFlag = 1;
      @(negedge clk);
    end
    chk("R10 cancel flags", int'(sawFlag), 0);
    checkTime("R10 loaded time kept");
    mH24 = 1'b0;
    loadTime(59, 59, 0, 4, 15, 8, 41);
    chk("R10 twelve midnight decode", tHour, 8'h12);
    oneSecond("R10 12h load advance", 0);
    mH24 = 1'b1;

    // R11 extra tick inside the window
    oneSecond("R11 busy tick", 1);

    // R8 R9 both flags in one cycle, alarm with don't-care
    mAie = 1'b1; mUie = 1'b1;
    loadTime(29, 14, 9, 3, 3, 3, 3);
    alSec = 8'h30; alMin = 8'hC5; alHour = 8'hFF;
    oneSecond("R8 R9 both flags", 0);
    chk("R9 both mask", flagSet, 0);
    alSec = 8'h30;
    oneSecond("R8 mismatch", 0);
    mUie = 1'b0;
    loadTime(29, 14, 21, 3, 3, 3, 3);
    mH24 = 1'b0;
    alSec = 8'h30; alMin = 8'h14; alHour = 8'h89;
    oneSecond("R8 12h alarm match", 0);
    mH24 = 1'b1;

    // random mix
    for (int it = 0; it < 60; it++) begin
      int s, mi, h, dw, dm, mo, y, dim;
      int sv[7];
      int nS, nM, nH;
      mBin = 1'($urandom % 2); mH24 = 1'($urandom % 2);
      mAie = 1'($urandom % 2); mUie = 1'($urandom % 2);
      mo = 1 + $urandom % 12;
      y  = $urandom % 100;
      dim = bDim(mo, y, 20);
      dm = ($urandom % 2) ? dim : 1 + $urandom % dim;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      s  = ($urandom % 2) ? 59 : $urandom % 60;
      dw = ($urandom % 2) ? 7 : 1 + $urandom % 7;
      loadTime(s, mi, h, dw, dm, mo, y);
      sv = '{mSec, mMin, mHour, mDow, mDom, mMon, mYear};
      stepModel();
      nS = bEnc(mSec, mBin); nM = bEnc(mMin, mBin); nH = bHour(mHour, mBin, mH24);
      mSec = sv[0]; mMin = sv[1]; mHour = sv[2]; mDow = sv[3];
      mDom = sv[4]; mMon = sv[5]; mYear = sv[6];
      case ($urandom % 3)
        0: alSec = 8'hC0 | 8'($urandom % 64);
        1: alSec = 8'(nS);
        default: alSec = 8'($urandom % 256);
      endcase
      case ($urandom % 3)
        0: alMin = 8'hC0 | 8'($urandom % 64);
        1: alMin = 8'(nM);
        default: alMin = 8'($urandom % 256);
      endcase
      case ($urandom % 3)
        0: alHour = 8'hC0 | 8'($urandom % 64);
        1: alHour = 8'(nH);
        default: alHour = 8'($urandom % 256);
      endcase
      oneSecond("R6 R7 R8 random", 0);
      oneSecond("R6 R7 R9 random second", 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule